// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block is an eight-stage shift register. It can capture a whole byte at once, or it can take in serial data one stage at a time. The serial output is taken from the last stage and is available both true and inverted. It lives inside a single system-clock domain and is driven by slow external-style control pins: a shift clock, a shift inhibit and an active-low load.

The three control pins and the serial input are synchronized into the system clock. The two clock pins are combined by OR. A rising edge of that combined level moves the data by one stage. As a result, either pin can act as the clock, and holding either pin high blocks the other one.

Holding load low keeps all stages continuously equal to the parallel bus, whatever the clock pins do. Releasing load leaves the captured byte in place, and the byte then drains out, the last stage first. The register is static and keeps its contents for as long as no shift or load happens.

Top module: `piso_shreg`

## Requirements
- R1: A synchronous active-high `sys_rst` clears all stages to zero, so `q` reads 0 and `q_n` reads 1.
- R2: While `load_n` is low, every stage follows the parallel bus. `par_in[0]` feeds the first stage and `par_in[7]` feeds the last stage, so `q` shows `par_in[7]` before any shift takes place.
- R3: While `load_n` is low, edges on `shift_clk` or `shift_inh` do not shift the register. After `load_n` is released, the loaded byte is intact.
- R4: With `load_n` high and `shift_inh` low, a rising edge on `shift_clk` shifts the register by exactly one stage.
- R5: With `load_n` high and `shift_clk` low, a rising edge on `shift_inh` shifts the register in the same way.
- R6: While either clock pin is held high, edges on the other pin produce no shift.
- R7: On each shift, `ser_in` enters the first stage, every other stage takes the value of the stage before it, and the old last-stage value is lost.
- R8: `q_n` is always the inverse of `q`.
- R9: Rising edges on both clock pins within the same system-clock sample count as a single shift.
- R10: With no shift and no load, the contents hold for any length of time.
- R11: A pin change reaches `q` at the third rising `sys_clk` edge after it is applied. Pin levels must persist for at least two system-clock periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| sys_rst | input | 1 | Synchronous active-high reset |
| par_in | input | 8 | Parallel byte; bit 0 is the first stage, bit 7 the last |
| ser_in | input | 1 | Serial data entering the first stage |
| load_n | input | 1 | Active-low level-sensitive parallel load |
| shift_clk | input | 1 | Shift clock pin (ORed with shift_inh) |
| shift_inh | input | 1 | Second clock pin, usable as active-high inhibit |
| q | output | 1 | Last-stage value |
| q_n | output | 1 | Inverse of the last-stage value |

## Verification
A qualified clock edge and an active load can arrive in the same synchronized sample, and so can rising edges on both clock pins. The bench provokes the first case with a load that is held low while the clock pins are pulsed, and with random runs that change `load_n` in the same step as a clock pin. The second case is driven by raising both pins together. Every step is judged against a bench model that lets the load win over a shift and counts coinciding edges as a single shift.

// File: rtl/piso_pkg.sv
package piso_pkg;

    localparam int unsigned PISO_WIDTH = 8;
    localparam int unsigned SYNC_DEPTH = 2;

    // synchronized pin bundle
    typedef struct packed {
        logic ser;
        logic load_n;
        logic inh;
        logic clk;
    } pin_t;

    localparam int unsigned PIN_BITS = $bits(pin_t);

    localparam pin_t PIN_IDLE = '{ser: 1'b0, load_n: 1'b1, inh: 1'b0, clk: 1'b0};

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_SHIFT = 2'd1,
        OP_LOAD  = 2'd2
    } op_e;

    // load overrides shift
    function automatic op_e op_decode(input logic load_active, input logic shift_edge);
        op_e r;
        if (load_active)
            r = OP_LOAD;
        else if (shift_edge)
            r = OP_SHIFT;
        else
            r = OP_HOLD;
        return r;
    endfunction

endpackage

// File: rtl/piso_sync.sv
module piso_sync #(
    parameter int unsigned W     = 4,
    parameter int unsigned DEPTH = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         sys_clk,
    input  logic         sys_rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);

    logic [W-1:0] chain [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_flop
        if (g == 0) begin : g_first
            always_ff @(posedge sys_clk) begin
                if (sys_rst)
                    chain[g] <= RST_VAL;
                else
                    chain[g] <= d_async;
            end
        end else begin : g_next
            always_ff @(posedge sys_clk) begin
                if (sys_rst)
                    chain[g] <= RST_VAL;
                else
                    chain[g] <= chain[g-1];
            end
        end
    end

    assign d_sync = chain[DEPTH-1];

endmodule

// File: rtl/piso_edge.sv
module piso_edge
    import piso_pkg::*;
(
    input  logic sys_clk,
    input  logic sys_rst,
    input  pin_t pins_s,
    output op_e  op,
    output logic ser_bit
);

    logic comb_lvl;
    logic comb_prev;
    logic shift_edge;

    assign comb_lvl = pins_s.clk | pins_s.inh;

    always_ff @(posedge sys_clk) begin
        if (sys_rst)
            comb_prev <= 1'b0;
        else
            comb_prev <= comb_lvl;
    end

    assign shift_edge = comb_lvl & ~comb_prev;
    assign op         = op_decode(~pins_s.load_n, shift_edge);
    assign ser_bit    = pins_s.ser;

    // R9
    single_shift_chk: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (op == OP_SHIFT) |=> (op != OP_SHIFT));

    // R6
    held_pin_block_chk: assert property (@(posedge sys_clk) disable iff (sys_rst)
        ($past(comb_lvl) && comb_lvl) |-> (op != OP_SHIFT));

endmodule

// File: rtl/piso_stages.sv
module piso_stages
    import piso_pkg::*;
#(
    parameter int unsigned W = PISO_WIDTH
) (
    input  logic         sys_clk,
    input  logic         sys_rst,
    input  op_e          op,
    input  logic         ser_bit,
    input  logic [W-1:0] par,
    output logic [W-1:0] stage
);

    for (genvar g = 0; g < W; g++) begin : g_stage
        logic feed;
        if (g == 0) begin : g_head
            assign feed = ser_bit;
        end else begin : g_body
            assign feed = stage[g-1];
        end

        always_ff @(posedge sys_clk) begin
            if (sys_rst)
                stage[g] <= 1'b0;
            else begin
                case (op)
                    OP_LOAD:  stage[g] <= par[g];
                    OP_SHIFT: stage[g] <= feed;
                    default:  stage[g] <= stage[g];
                endcase
            end
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge sys_clk)
        sys_rst |=> (stage == '0));

    // R2
    load_capture_chk: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (op == OP_LOAD) |=> (stage == $past(par)));

    // R7
    shift_move_chk: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (op == OP_SHIFT) |=> (stage == {$past(stage[W-2:0]), $past(ser_bit)}));

    // R10
    hold_static_chk: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (op == OP_HOLD) |=> $stable(stage));

endmodule

// File: rtl/piso_shreg.sv
module piso_shreg
    import piso_pkg::*;
#(
    parameter int unsigned WIDTH = PISO_WIDTH,
    parameter int unsigned SYNC  = SYNC_DEPTH
) (
    input  logic             sys_clk,
    input  logic             sys_rst,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_in,
    input  logic             load_n,
    input  logic             shift_clk,
    input  logic             shift_inh,
    output logic             q,
    output logic             q_n
);

    localparam int unsigned LAST = WIDTH - 1;

    pin_t             pins_raw;
    logic [PIN_BITS-1:0] pins_vec;
    pin_t             pins_s;
    op_e              op;
    logic             ser_bit;
    logic [WIDTH-1:0] stage;

    assign pins_raw = '{ser: ser_in, load_n: load_n, inh: shift_inh, clk: shift_clk};

    piso_sync #(
        .W      (PIN_BITS),
        .DEPTH  (SYNC),
        .RST_VAL(PIN_IDLE)
    ) u_sync (
        .sys_clk(sys_clk),
        .sys_rst(sys_rst),
        .d_async(pins_raw),
        .d_sync (pins_vec)
    );

    assign pins_s = pin_t'(pins_vec);

    piso_edge u_edge (
        .sys_clk(sys_clk),
        .sys_rst(sys_rst),
        .pins_s (pins_s),
        .op     (op),
        .ser_bit(ser_bit)
    );

    piso_stages #(.W(WIDTH)) u_stages (
        .sys_clk(sys_clk),
        .sys_rst(sys_rst),
        .op     (op),
        .ser_bit(ser_bit),
        .par    (par_in),
        .stage  (stage)
    );

    assign q   = stage[LAST];
    assign q_n = ~stage[LAST];

    // R3
    load_beats_clock_chk: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (!pins_s.load_n) |-> (op == OP_LOAD));

endmodule

// File: tb/piso_shreg_bench.sv
module piso_shreg_bench;

    localparam int W = 8;

    logic         sys_clk = 1'b0;
    logic         sys_rst = 1'b1;
    logic [W-1:0] par_in  = '0;
    logic         ser_in  = 1'b0;
    logic         load_n  = 1'b1;
    logic         shift_clk = 1'b0;
    logic         shift_inh = 1'b0;
    logic         q, q_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [W-1:0] m;          // model: m[0] first stage, m[W-1] last stage
    logic         prev_or;

    always #2 sys_clk = ~sys_clk;   // 250 MHz

    piso_shreg u_piso_shreg (
        .sys_clk  (sys_clk),
        .sys_rst  (sys_rst),
        .par_in   (par_in),
        .ser_in   (ser_in),
        .load_n   (load_n),
        .shift_clk(shift_clk),
        .shift_inh(shift_inh),
        .q        (q),
        .q_n      (q_n)
    );

    initial begin : watchdog
        int cyc;
        for (cyc = 0; cyc < 150000 && !done; cyc++) @(posedge sys_clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: act=hung exp=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act=%0b exp=%0b", req, act, exp);
        end
    endtask

    task automatic check_out(input string req);
        check(req, q, m[W-1]);
        check({req, "/R8"}, q_n, ~m[W-1]);
    endtask

    function automatic logic [W-1:0] model_step(input logic [W-1:0] cur, input logic c,
                                                input logic i, input logic l, input logic s,
                                                input logic p_or, input logic [W-1:0] p);
        if (!l)
            return p;
        else if ((c | i) && !p_or)
            return {cur[W-2:0], s};
        return cur;
    endfunction

    task automatic apply(input logic c, input logic i, input logic l, input logic s,
                         input string req);
        m       = model_step(m, c, i, l, s, prev_or, par_in);
        prev_or = c | i;
        shift_clk = c;
        shift_inh = i;
        load_n    = l;
        ser_in    = s;
        repeat (4) @(negedge sys_clk);
        check_out(req);
    endtask

    task automatic set_par(input logic [W-1:0] p, input string req);
        par_in = p;
        if (!load_n) m = p;
        repeat (4) @(negedge sys_clk);
        check_out(req);
    endtask

    task automatic pulse_clk(input logic s, input string req);
        apply(1'b1, 1'b0, 1'b1, s, req);
        apply(1'b0, 1'b0, 1'b1, s, req);
    endtask

    initial begin : stim
        logic [W-1:0] hold_val;
        void'($urandom(32'd20250611));
        m = '0;
        prev_or = 1'b0;
        repeat (5) @(negedge sys_clk);
        sys_rst = 1'b0;
        @(negedge sys_clk);
        // R1 reset state
        check("R1 q", q, 1'b0);
        check("R1 q_n", q_n, 1'b1);

        // R2 load: last stage visible at once
        par_in = 8'b1010_1011;
        apply(1'b0, 1'b0, 1'b0, 1'b0, "R2");
        set_par(8'b0111_1111, "R2 follow");
        // R3 clock edges ignored while loading
        apply(1'b1, 1'b0, 1'b0, 1'b0, "R3 clk");
        apply(1'b0, 1'b0, 1'b0, 1'b0, "R3 clk low");
        apply(1'b0, 1'b1, 1'b0, 1'b0, "R3 inh");
        apply(1'b0, 1'b0, 1'b0, 1'b0, "R3 inh low");
        apply(1'b0, 1'b0, 1'b1, 1'b0, "R3 release");

        // R11 latency: q goes 0 -> 1 at the third edge
        m = {m[W-2:0], 1'b0};
        prev_or = 1'b1;
        shift_clk = 1'b1;
        repeat (2) @(negedge sys_clk);
        check("R11 before", q, 1'b0);
        @(negedge sys_clk);
        check("R11 after", q, 1'b1);
        @(negedge sys_clk);
        apply(1'b0, 1'b0, 1'b1, 1'b0, "R4 low");

        // R4 shifting via the clock pin
        par_in = 8'b0101_0101;
        apply(1'b0, 1'b0, 1'b0, 1'b0, "R4 load");
        apply(1'b0, 1'b0, 1'b1, 1'b0, "R4 release");
        pulse_clk(1'b1, "R4");
        pulse_clk(1'b0, "R4");

        // R5 shifting via the inhibit pin
        apply(1'b0, 1'b1, 1'b1, 1'b1, "R5");
        apply(1'b0, 1'b0, 1'b1, 1'b1, "R5 low");
        apply(1'b0, 1'b1, 1'b1, 1'b0, "R5 again");
        apply(1'b0, 1'b0, 1'b1, 1'b0, "R5 low");

        // R6 clock held high blocks inhibit edges, and vice versa
        apply(1'b1, 1'b0, 1'b1, 1'b1, "R6 clk up");
        hold_val = m;
        apply(1'b1, 1'b1, 1'b1, 1'b0, "R6 inh up");
        apply(1'b1, 1'b0, 1'b1, 1'b0, "R6 inh down");
        apply(1'b1, 1'b1, 1'b1, 1'b1, "R6 inh up2");
        apply(1'b0, 1'b1, 1'b1, 1'b1, "R6 clk down");
        apply(1'b1, 1'b1, 1'b1, 1'b0, "R6 clk under inh");
        apply(1'b0, 1'b0, 1'b1, 1'b0, "R6 both low");
        checks++;
        if (m !== hold_val) begin
            errors++;
            $display("FAIL R6 model: act=%b exp=%b", m, hold_val);
        end

        // R9 both pins rising together: one shift
        apply(1'b1, 1'b1, 1'b1, 1'b1, "R9");
        apply(1'b0, 1'b0, 1'b1, 1'b0, "R9 low");

        // R7 serial fill: pattern emerges at the last stage
        for (int k = 0; k < W + 2; k++)
            pulse_clk(logic'((8'b1100_1011 >> (k % W)) & 1), "R7");

        // R10 long idle
        hold_val = m;
        repeat (2000) @(negedge sys_clk);
        check_out("R10");

        // mid-sequence load then drain
        par_in = 8'b1001_0110;
        pulse_clk(1'b1, "R7 pre");
        apply(1'b0, 1'b0, 1'b0, 1'b1, "R2 mid");
        apply(1'b0, 1'b0, 1'b1, 1'b1, "R2 mid rel");
        for (int k = 0; k < W; k++) pulse_clk(1'b0, "R7 drain");

        // random mix
        for (int n = 0; n < 600; n++) begin
            int unsigned r;
            r = $urandom % 8;
            if (r == 0)
                set_par(W'($urandom), "R2 rand par");
            else
                apply(logic'($urandom & 1), logic'($urandom & 1),
                      (($urandom % 5) != 0), logic'($urandom & 1), "R4/R5/R6 rand");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule